// File: doc/BRIEF.md
# Cartridge Address Decoder with Bank Registers

This block sits between a host bus with a 24-bit address (8-bit bank, 16-bit offset) and the memories of a cartridge. On each access it works out one of three results. It can select one of four ROM chips and give the address inside that chip. It can select the battery-backed RAM and give the RAM address. It can answer from one of its own four bank registers. If the access falls in a window the cartridge owns but does not decode, it raises an open-bus flag.

The decode is combinational and depends on the address, the strobes and the bank registers. The register file holds five bits in each register: a high mirror flag and a 4-bit region number. In the upper half of the map, banks 0xC0–0xFF, each 16-bank group shows a 1 MB ROM region chosen by one register. In the lower ROM window, offsets 0x8000–0xFFFF of the system banks, the ROM is mapped linearly. Two of the mirror flags can fold the top half of that window onto its bottom half. The system banks are 0x00–0x3F and 0x80–0xBF.

Top module: `cart_map_decoder`

## Requirements
- R1: A bank register keeps only bit 7 and bits 3..0. A read returns `{bit7, 3'b000, bits3..0}`, so writing 0xFF reads back 0x8F. Registers are at offsets 0x4804–0x4807 of the system banks, with index = offset[1:0]. They are written when `wr` is high at a clock edge and read combinationally with `reg_valid` high while `rd` is high.
- R2: After reset the registers at 0x4804, 0x4805, 0x4806 and 0x4807 read 0x00, 0x01, 0x02 and 0x03. A register changes only on a write to its own address.
- R3: A read at offset 0x8000–0xFFFF of a system bank selects chip 0. The linear ROM address is `{bank[5:0], offset[14:0]}`, which covers the first 16 Mbit. The region bits of the registers have no effect on this window.
- R4: While bit 7 of register 0x4805 is set, banks 0x20–0x3F in the lower window map as banks 0x00–0x1F. While bit 7 of register 0x4807 is set, banks 0xA0–0xBF map as banks 0x80–0x9F. Each flag affects only its own half of the map.
- R5: Bit 7 of the registers at 0x4804 and 0x4806 is stored and read back but changes no mapping.
- R6: The RAM is selected at offsets 0x6000–0x7FFF of the system banks, with RAM address = offset[12:0]. It is also selected over all of banks 0x70–0x73, with RAM address = `{bank[1:0], offset}` truncated to RAM_AW bits. A RAM select never coincides with a ROM select.
- R7: Banks 0x40–0x7F, other than 0x70–0x73, produce no select and no open-bus flag.
- R8: A read at offset 0x4802–0x4803 or 0x4808–0x480F of a system bank selects ROM at the linear address equal to the offset, with the bank taken as zero. It returns no register data.
- R9: A read at offset 0x2200–0x4801 or 0x4810–0x5FFF of a system bank raises `open_bus` and drives no select.
- R10: Banks 0xC0–0xFF map the linear address `{reg[3:0], bank[3:0], offset}`. The register is chosen by bank[5:4]: 0xC0 uses 0x4804, 0xD0 uses 0x4805, 0xE0 uses 0x4806 and 0xF0 uses 0x4807.
- R11: Bits 23..22 of the 24-bit linear address pick one active-low ROM select, `rom_cs_n[k]` low for chip k. `rom_addr` is linear[21:0].
- R12: ROM selects, `reg_valid` and `open_bus` are asserted only while `rd` is high. The RAM select is asserted while `rd` or `wr` is high. Writes to fall-through or ROM addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 24 | Host address, bank in [23:16] |
| wdata | input | 8 | Host write data |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| rom_cs_n | output | 4 | Active-low ROM chip selects |
| rom_addr | output | 22 | Address within the selected ROM chip |
| ram_cs | output | 1 | RAM select |
| ram_addr | output | RAM_AW | RAM address |
| reg_valid | output | 1 | Register read data is valid |
| reg_rdata | output | 8 | Register read data |
| open_bus | output | 1 | Undecoded cartridge window |

## Verification
On every cycle, the assertions check these properties:
- At most one ROM chip is selected, and ROM and RAM are never selected together.
- An open-bus access drives nothing else.
- Register reads carry zeros in bits 6..4.
- Without a read strobe no ROM chip is selected.
- The lower window always maps to chip 0 within 16 Mbit.
- The mid banks stay silent.

The exact linear address, the effect of the mirror flags, the register-to-bank-group assignment, the fall-through offsets and the reset contents need known register values. Only the bench's scenarios can show these.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
    localparam int LIN_W     = 24;
    localparam int CHIP_BITS = 2;
    localparam int CHIP_N    = 1 << CHIP_BITS;
    localparam int CHIP_AW   = LIN_W - CHIP_BITS;
    localparam int REG_N     = 4;
    localparam int RAM_FULLW = 18;

    typedef struct packed {
        logic       mir;
        logic [3:0] rgn;
    } bankreg_t;

    typedef enum logic [2:0] {
        DK_NONE,
        DK_ROM,
        DK_FALL,
        DK_RAM,
        DK_REG,
        DK_OPEN
    } dkind_e;
endpackage

// File: rtl/cmap_bankregs.sv
module cmap_bankregs
    import cmap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [1:0]            idx,
    input  logic [7:0]            wdata,
    output bankreg_t [REG_N-1:0]  regs
);
    typedef struct packed {
        bankreg_t [REG_N-1:0] r;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.r[idx].mir = wdata[7];
            st_d.r[idx].rgn = wdata[3:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_N; i++) begin
                st_q.r[i].mir <= 1'b0;
                st_q.r[i].rgn <= 4'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q.r;
endmodule

// File: rtl/cmap_decode.sv
module cmap_decode
    import cmap_pkg::*;
#(
    parameter int RAM_AW = 15
) (
    input  logic [23:0]           addr,
    input  bankreg_t [REG_N-1:0]  regs,
    output dkind_e                kind,
    output logic [LIN_W-1:0]      lin,
    output logic [RAM_AW-1:0]     ram_addr,
    output logic [1:0]            reg_idx
);
    logic [7:0]           bank;
    logic [15:0]          off;
    logic                 fold;
    logic [5:0]           page;
    logic [RAM_FULLW-1:0] ram_full;

    assign bank    = addr[23:16];
    assign off     = addr[15:0];
    assign reg_idx = off[1:0];
    assign fold    = bank[7] ? regs[3].mir : regs[1].mir;
    assign page    = {bank[5] & ~fold, bank[4:0]};

    always_comb begin
        kind     = DK_NONE;
        lin      = '0;
        ram_full = '0;
        if (!bank[6]) begin
            if (off[15]) begin
                kind = DK_ROM;
                lin  = {3'b000, page, off[14:0]};
            end else if (off[14:13] == 2'b11) begin
                kind     = DK_RAM;
                ram_full = {5'b0, off[12:0]};
            end else if (off[15:4] == 12'h480) begin
                unique case (off[3:0])
                    4'h0, 4'h1:             kind = DK_OPEN;
                    4'h4, 4'h5, 4'h6, 4'h7: kind = DK_REG;
                    default: begin
                        kind = DK_FALL;
                        lin  = {8'h00, off};
                    end
                endcase
            end else if (off >= 16'h2200) begin
                kind = DK_OPEN;
            end
        end else if (!bank[7]) begin
            if (bank[5:2] == 4'b1100) begin
                kind     = DK_RAM;
                ram_full = {bank[1:0], off};
            end
        end else begin
            kind = DK_ROM;
            lin  = {regs[bank[5:4]].rgn, bank[3:0], off};
        end
    end

    assign ram_addr = ram_full[RAM_AW-1:0];
endmodule

// File: rtl/cart_map_decoder.sv
module cart_map_decoder
    import cmap_pkg::*;
#(
    parameter int RAM_AW = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [23:0]        addr,
    input  logic [7:0]         wdata,
    input  logic               rd,
    input  logic               wr,
    output logic [3:0]         rom_cs_n,
    output logic [21:0]        rom_addr,
    output logic               ram_cs,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic               reg_valid,
    output logic [7:0]         reg_rdata,
    output logic               open_bus
);
    bankreg_t [REG_N-1:0] regs;
    dkind_e               kind;
    logic [LIN_W-1:0]     lin;
    logic [1:0]           reg_idx;
    logic                 rom_rd;

    cmap_bankregs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr && kind == DK_REG),
        .idx   (reg_idx),
        .wdata (wdata),
        .regs  (regs)
    );

    cmap_decode #(.RAM_AW(RAM_AW)) u_dec (
        .addr     (addr),
        .regs     (regs),
        .kind     (kind),
        .lin      (lin),
        .ram_addr (ram_addr),
        .reg_idx  (reg_idx)
    );

    assign rom_rd   = rd && (kind == DK_ROM || kind == DK_FALL);
    assign rom_addr = lin[CHIP_AW-1:0];

    for (genvar c = 0; c < CHIP_N; c++) begin : g_cs
        assign rom_cs_n[c] = !(rom_rd && lin[LIN_W-1 -: CHIP_BITS] == CHIP_BITS'(c));
    end

    assign ram_cs    = (rd || wr) && kind == DK_RAM;
    assign reg_valid = rd && kind == DK_REG;
    assign reg_rdata = reg_valid ? {regs[reg_idx].mir, 3'b000, regs[reg_idx].rgn} : 8'h00;
    assign open_bus  = rd && kind == DK_OPEN;
endmodule

// File: rtl/cmap_checker.sv
module cmap_checker #(
    parameter int RAM_AW = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [23:0]       addr,
    input logic              rd,
    input logic              wr,
    input logic [3:0]        rom_cs_n,
    input logic [21:0]       rom_addr,
    input logic              ram_cs,
    input logic              reg_valid,
    input logic [7:0]        reg_rdata,
    input logic              open_bus
);
    p_cs_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~rom_cs_n));

    p_rom_ram_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> rom_cs_n == 4'hF);

    p_open_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        open_bus |-> (rom_cs_n == 4'hF && !ram_cs && !reg_valid));

    p_readmask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid |-> reg_rdata[6:4] == 3'b000);

    p_nord_norom_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (rom_cs_n == 4'hF && !open_bus && !reg_valid));

    p_midbanks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[23:22] == 2'b01 && addr[21:18] != 4'b1100) |->
        (rom_cs_n == 4'hF && !ram_cs && !open_bus && !reg_valid));

    p_lowwin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !addr[22] && addr[15]) |-> (rom_cs_n == 4'b1110 && !rom_addr[21]));

    p_regstable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && $past(reg_valid) && !$past(wr) && $stable(addr)) |-> $stable(reg_rdata));
endmodule

bind cart_map_decoder cmap_checker #(.RAM_AW(RAM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rd        (rd),
    .wr        (wr),
    .rom_cs_n  (rom_cs_n),
    .rom_addr  (rom_addr),
    .ram_cs    (ram_cs),
    .reg_valid (reg_valid),
    .reg_rdata (reg_rdata),
    .open_bus  (open_bus)
);

// File: tb/cart_map_decoder_test.sv
module cart_map_decoder_test;
    localparam int RAM_AW = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [23:0]       addr = '0;
    logic [7:0]        wdata = '0;
    logic              rd = 1'b0;
    logic              wr = 1'b0;
    logic [3:0]        rom_cs_n;
    logic [21:0]       rom_addr;
    logic              ram_cs;
    logic [RAM_AW-1:0] ram_addr;
    logic              reg_valid;
    logic [7:0]        reg_rdata;
    logic              open_bus;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cart_map_decoder #(.RAM_AW(RAM_AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
        .rom_cs_n(rom_cs_n), .rom_addr(rom_addr), .ram_cs(ram_cs), .ram_addr(ram_addr),
        .reg_valid(reg_valid), .reg_rdata(reg_rdata), .open_bus(open_bus)
    );

    typedef struct packed {
        logic [23:0] a;
        logic [3:0]  cs;
        logic [21:0] ra;
        logic        rc;
        logic [14:0] ma;
        logic        ob;
    } vec_t;

    // rd held high, default register contents
    localparam vec_t TBL [19] = '{
        '{24'h008000, 4'b1110, 22'h000000, 1'b0, 15'h0000, 1'b0}, // R3
        '{24'h3FFFFF, 4'b1110, 22'h1FFFFF, 1'b0, 15'h0000, 1'b0}, // R3
        '{24'h95C000, 4'b1110, 22'h0AC000, 1'b0, 15'h0000, 1'b0}, // R3
        '{24'h006000, 4'b1111, 22'h000000, 1'b1, 15'h0000, 1'b0}, // R6
        '{24'hBF7FFF, 4'b1111, 22'h000000, 1'b1, 15'h1FFF, 1'b0}, // R6
        '{24'h73ABCD, 4'b1111, 22'h000000, 1'b1, 15'h2BCD, 1'b0}, // R6
        '{24'h458000, 4'b1111, 22'h000000, 1'b0, 15'h0000, 1'b0}, // R7
        '{24'h7DFFFF, 4'b1111, 22'h000000, 1'b0, 15'h0000, 1'b0}, // R7
        '{24'h004802, 4'b1110, 22'h004802, 1'b0, 15'h0000, 1'b0}, // R8
        '{24'h80480F, 4'b1110, 22'h00480F, 1'b0, 15'h0000, 1'b0}, // R8
        '{24'h002200, 4'b1111, 22'h000000, 1'b0, 15'h0000, 1'b1}, // R9
        '{24'h3F47FF, 4'b1111, 22'h000000, 1'b0, 15'h0000, 1'b1}, // R9
        '{24'h004810, 4'b1111, 22'h000000, 1'b0, 15'h0000, 1'b1}, // R9
        '{24'h805FFF, 4'b1111, 22'h000000, 1'b0, 15'h0000, 1'b1}, // R9
        '{24'h004801, 4'b1111, 22'h000000, 1'b0, 15'h0000, 1'b1}, // R9
        '{24'hC00000, 4'b1110, 22'h000000, 1'b0, 15'h0000, 1'b0}, // R10
        '{24'hD51234, 4'b1110, 22'h151234, 1'b0, 15'h0000, 1'b0}, // R10
        '{24'hE00000, 4'b1110, 22'h200000, 1'b0, 15'h0000, 1'b0}, // R10
        '{24'hFFFFFF, 4'b1110, 22'h3FFFFF, 1'b0, 15'h0000, 1'b0}  // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [23:0] a);
        @(negedge clk);
        wr = 1'b0; rd = 1'b1; addr = a;
        #1;
    endtask

    task automatic do_write(input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        rd = 1'b0; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rom_expect(input string req, input logic [23:0] a,
                              input logic [3:0] cs, input logic [21:0] ra);
        do_read(a);
        check(req, 32'(rom_cs_n), 32'(cs));
        check(req, 32'(rom_addr), 32'(ra));
    endtask

    task automatic reg_expect(input string req, input logic [23:0] a, input logic [7:0] v);
        do_read(a);
        check(req, 32'(reg_valid), 32'd1);
        check(req, 32'(reg_rdata), 32'(v));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset contents
        reg_expect("R2", 24'h004804, 8'h00);
        reg_expect("R2", 24'h004805, 8'h01);
        reg_expect("R2", 24'h804806, 8'h02);
        reg_expect("R2", 24'h804807, 8'h03);

        foreach (TBL[i]) begin
            do_read(TBL[i].a);
            check("R3/R6-R10 table", 32'(rom_cs_n), 32'(TBL[i].cs));
            if (TBL[i].cs != 4'hF) check("R3/R8/R10 table", 32'(rom_addr), 32'(TBL[i].ra));
            check("R6 table", 32'(ram_cs), 32'(TBL[i].rc));
            if (TBL[i].rc) check("R6 table", 32'(ram_addr), 32'(TBL[i].ma));
            check("R9 table", 32'(open_bus), 32'(TBL[i].ob));
            check("R8 table", 32'(reg_valid), 32'd0);
        end

        // R1 mask, R5 inert high flags
        do_write(24'h004804, 8'hFF);
        do_write(24'h804806, 8'h82);
        reg_expect("R1", 24'h004804, 8'h8F);
        reg_expect("R5", 24'h004806, 8'h82);
        rom_expect("R5", 24'h258000, 4'b1110, 22'h128000);
        rom_expect("R5", 24'hA58000, 4'b1110, 22'h128000);
        rom_expect("R3", 24'h958000, 4'b1110, 22'h0A8000);
        // R11 region 15 -> chip 3
        rom_expect("R11", 24'hC00010, 4'b0111, 22'h300010);
        rom_expect("R10", 24'hE00000, 4'b1110, 22'h200000);

        do_write(24'h004804, 8'h07);
        rom_expect("R11", 24'hC30010, 4'b1101, 22'h330010);

        // R4 mirror of the upper half only
        do_write(24'h004807, 8'h8C);
        rom_expect("R4", 24'hB59000, 4'b1110, 22'h0A9000);
        rom_expect("R4", 24'hA08000, 4'b1110, 22'h000000);
        rom_expect("R4", 24'h359000, 4'b1110, 22'h1A9000);
        rom_expect("R11", 24'hF10000, 4'b0111, 22'h010000);
        rom_expect("R4", 24'h959000, 4'b1110, 22'h0A9000);
        do_write(24'h004805, 8'h80);
        rom_expect("R4", 24'h359000, 4'b1110, 22'h0A9000);
        rom_expect("R10", 24'hD00000, 4'b1110, 22'h000000);
        reg_expect("R4", 24'h004805, 8'h80);

        // R12 strobe gating and ignored writes
        @(negedge clk); rd = 1'b0; wr = 1'b0; addr = 24'h008000; #1;
        check("R12", 32'(rom_cs_n), 32'hF);
        @(negedge clk); addr = 24'h002200; #1;
        check("R12", 32'(open_bus), 32'd0);
        @(negedge clk); wr = 1'b1; addr = 24'h006123; #1;
        check("R12", 32'(ram_cs), 32'd1);
        check("R12", 32'(ram_addr), 32'h0123);
        @(negedge clk); addr = 24'h008000; #1;
        check("R12", 32'(rom_cs_n), 32'hF);
        @(negedge clk); wr = 1'b0;
        do_write(24'h004808, 8'h55);
        do_write(24'h404805, 8'h0F);
        reg_expect("R12", 24'h004805, 8'h80);
        rom_expect("R12", 24'h004808, 4'b1110, 22'h004808);
        check("R12", 32'(reg_valid), 32'd0);

        @(negedge clk); rd = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule